// File: doc/BRIEF.md
# Programmable-Format Serial Receiver

This block recovers characters from an asynchronous serial line. It oversamples the line with a tick that runs at sixteen times the bit rate. A six-bit line-format word sets the framing of each character: how many data bits it has, whether a parity bit follows them, and which parity rule applies. The transmitter on the same line uses the same format word.

A character starts on a falling edge of the idle-high line. The receiver checks the start bit at its midpoint, then samples each following bit at its centre. When the character ends, the block holds the byte together with its parity-error, framing-error and break flags. It raises data-ready at the same time. A read strobe from the consumer clears data-ready. If a new character ends before the previous one was read, the overrun flag goes high.

The format word is captured when each start edge is seen, so changing it in the middle of a character has no effect on that character. Exactly one stop bit is checked, whatever the stop-bit setting is.

Top module: `serfmt_rx`

## Requirements
- R1: The number of data bits follows format bits [1:0]: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Data is received least significant bit first, and rx_byte bits above the configured length read as zero.
- R2: With format bit 3 set, one parity bit is expected after the last data bit. If format bit 4 is set, the total number of ones in the data plus the parity bit must be even; if it is clear, that total must be odd. A mismatch sets parity_err.
- R3: With format bits 3 and 5 both set, the expected parity bit is the inverse of format bit 4, whatever the data is. A mismatch sets parity_err.
- R4: Exactly one stop bit is sampled, even when format bit 2 asks for two. A new start edge that comes straight after a single stop bit is received correctly.
- R5: A low stop-bit sample sets framing_err for that character.
- R6: When every data bit, the parity bit (if enabled) and the stop bit are all sampled low, break_det is set, and framing_err is set as well.
- R7: A low pulse that is high again at the start-bit midpoint (8 ticks after the edge) is treated as a glitch. No character is delivered and data_ready stays unchanged.
- R8: data_ready rises when a character completes, and rx_byte and the flags then hold that character. A one-cycle rd_strobe clears data_ready.
- R9: If a character completes while data_ready is still set, overrun is set and rx_byte holds the new character. rd_strobe clears overrun.
- R10: After reset, data_ready, overrun, parity_err, framing_err and break_det are 0, and rx_byte is 0.
- R11: With format bit 3 clear, no parity bit is expected and parity_err stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_in | input | 1 | Asynchronous serial input, idle high |
| tick16 | input | 1 | One-cycle pulse at 16x the bit rate |
| line_ctl | input | 6 | Line format: [1:0] length, [2] two stop, [3] parity enable, [4] even, [5] stick |
| rd_strobe | input | 1 | Consumer has read rx_byte |
| rx_byte | output | 8 | Last received character |
| data_ready | output | 1 | Unread character available |
| parity_err | output | 1 | Parity mismatch on rx_byte |
| framing_err | output | 1 | Stop bit sampled low on rx_byte |
| break_det | output | 1 | Whole character sampled low |
| overrun | output | 1 | Character completed while unread |

## Verification
The bench sends each word length and compares the upper bits with zero. A receiver that shifts from the wrong end, or that counts bits wrongly, would return a misaligned byte. The bench sends both correct and flipped parity bits under even, odd and both stick settings. A design that computes stick parity from the data, or that reverses the sense of even and odd, would flag the wrong characters. It sends back-to-back characters with a two-stop setting and a single stop bit between them. A receiver that waits for a second stop bit would miss the next start edge. Low stop bits with and without data ones separate a plain framing error from a break. A short low glitch must not produce a character, and an unread character followed by a second one must raise overrun.

// File: rtl/serfmt_rx_pkg.sv
package serfmt_rx_pkg;

    // Line format word; field positions are shared with the transmitter.
    typedef struct packed {
        logic       stick;     // [5]
        logic       even;      // [4]
        logic       par_en;    // [3]
        logic       two_stop;  // [2] transmit only
        logic [1:0] wlen;      // [1:0] 5..8 data bits
    } line_fmt_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic       perr;
        logic       ferr;
        logic       brk;
    } rx_result_t;

    // Index of the last data bit for a length code.
    function automatic logic [2:0] last_bit_idx(input logic [1:0] wlen);
        return {1'b0, wlen} + 3'd4;
    endfunction

    // Parity bit the receiver expects; unused data bits are zero.
    function automatic logic expected_parity(input logic [7:0] d, input line_fmt_t f);
        if (f.stick) return ~f.even;
        return f.even ? (^d) : ~(^d);
    endfunction

endpackage

// File: rtl/serfmt_rx_sync.sv
module serfmt_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) q <= '1;
                else     q <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) q <= '1;
                else     q <= {q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = q[STAGES-1];
endmodule

// File: rtl/serfmt_rx_ctrl.sv
module serfmt_rx_ctrl
    import serfmt_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_s,
    input  logic       tick,
    input  line_fmt_t  fmt,
    output logic       done,
    output rx_result_t res
);
    localparam int CW = $clog2(OVS);
    localparam logic [CW-1:0] MID_C  = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] LAST_C = CW'(OVS - 1);

    rx_state_e  state;
    logic [CW-1:0] cnt;
    logic [2:0] idx;
    logic [7:0] shreg;
    line_fmt_t  fmt_q;
    logic       seen_high;
    logic       perr_q;
    logic       rx_prev;

    wire sample_pt = tick && (cnt == LAST_C);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            idx       <= '0;
            shreg     <= '0;
            fmt_q     <= '0;
            seen_high <= 1'b0;
            perr_q    <= 1'b0;
            rx_prev   <= 1'b1;
            done      <= 1'b0;
            res       <= '0;
        end else begin
            done    <= 1'b0;
            rx_prev <= rx_s;
            case (state)
                ST_IDLE: begin
                    if (rx_prev && !rx_s) begin
                        state <= ST_START;
                        cnt   <= '0;
                        fmt_q <= fmt;
                    end
                end
                ST_START: begin
                    if (tick) begin
                        if (cnt == MID_C) begin
                            if (rx_s) begin
                                state <= ST_IDLE;
                            end else begin
                                state     <= ST_DATA;
                                cnt       <= '0;
                                idx       <= '0;
                                shreg     <= '0;
                                seen_high <= 1'b0;
                                perr_q    <= 1'b0;
                            end
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                end
                ST_DATA: begin
                    if (sample_pt) begin
                        cnt        <= '0;
                        shreg[idx] <= rx_s;
                        seen_high  <= seen_high | rx_s;
                        if (idx == last_bit_idx(fmt_q.wlen))
                            state <= fmt_q.par_en ? ST_PAR : ST_STOP;
                        else
                            idx <= idx + 3'd1;
                    end else if (tick) begin
                        cnt <= cnt + CW'(1);
                    end
                end
                ST_PAR: begin
                    if (sample_pt) begin
                        cnt       <= '0;
                        seen_high <= seen_high | rx_s;
                        perr_q    <= rx_s != expected_parity(shreg, fmt_q);
                        state     <= ST_STOP;
                    end else if (tick) begin
                        cnt <= cnt + CW'(1);
                    end
                end
                ST_STOP: begin
                    if (sample_pt) begin
                        cnt       <= '0;
                        done      <= 1'b1;
                        res.data  <= shreg;
                        res.perr  <= perr_q;
                        res.ferr  <= !rx_s;
                        res.brk   <= !rx_s && !seen_high;
                        state     <= ST_IDLE;
                    end else if (tick) begin
                        cnt <= cnt + CW'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R1: a 5-bit character never carries upper bits
    a_r1_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (done && fmt_q.wlen == 2'b00) |-> (res.data[7:5] == 3'b000));

    // R7: high at start midpoint returns to idle
    a_r7_glitch_idle: assert property (@(posedge clk) disable iff (rst)
        (state == ST_START && tick && cnt == MID_C && rx_s) |=> (state == ST_IDLE));

    // R4: after the single stop sample the receiver is idle, even with two stops set
    a_r4_single_stop: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STOP && sample_pt && fmt_q.two_stop) |=> (state == ST_IDLE));

    // R11: no parity error without parity
    a_r11_no_perr: assert property (@(posedge clk) disable iff (rst)
        (done && !fmt_q.par_en) |-> !res.perr);

    // R6: break implies framing error
    a_r6_brk_ferr: assert property (@(posedge clk) disable iff (rst)
        (done && res.brk) |-> res.ferr);
endmodule

// File: rtl/serfmt_rx_flags.sv
module serfmt_rx_flags
    import serfmt_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       done,
    input  rx_result_t res,
    input  logic       rd,
    output rx_result_t held,
    output logic       ready,
    output logic       ovr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held  <= '0;
            ready <= 1'b0;
            ovr   <= 1'b0;
        end else if (done) begin
            held  <= res;
            ready <= 1'b1;
            ovr   <= ready && !rd;
        end else if (rd) begin
            ready <= 1'b0;
            ovr   <= 1'b0;
        end
    end

    // R8: completion raises data-ready
    a_r8_ready_set: assert property (@(posedge clk) disable iff (rst)
        done |=> ready);

    // R8: a read without completion clears data-ready
    a_r8_read_clear: assert property (@(posedge clk) disable iff (rst)
        (rd && !done) |=> !ready);

    // R9: overrun only rises over an unread character
    a_r9_ovr_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr) |-> $past(ready));
endmodule

// File: rtl/serfmt_rx.sv
module serfmt_rx
    import serfmt_rx_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_in,
    input  logic       tick16,
    input  logic [5:0] line_ctl,
    input  logic       rd_strobe,
    output logic [7:0] rx_byte,
    output logic       data_ready,
    output logic       parity_err,
    output logic       framing_err,
    output logic       break_det,
    output logic       overrun
);
    logic       rx_s;
    logic       done;
    rx_result_t res;
    rx_result_t held;

    serfmt_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rx_in),
        .dout (rx_s)
    );

    serfmt_rx_ctrl #(.OVS(OVS)) u_ctrl (
        .clk  (clk),
        .rst  (rst),
        .rx_s (rx_s),
        .tick (tick16),
        .fmt  (line_fmt_t'(line_ctl)),
        .done (done),
        .res  (res)
    );

    serfmt_rx_flags u_flags (
        .clk   (clk),
        .rst   (rst),
        .done  (done),
        .res   (res),
        .rd    (rd_strobe),
        .held  (held),
        .ready (data_ready),
        .ovr   (overrun)
    );

    assign rx_byte     = held.data;
    assign parity_err  = held.perr;
    assign framing_err = held.ferr;
    assign break_det   = held.brk;
endmodule

// File: tb/test_serfmt_rx.sv
module test_serfmt_rx;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_in = 1'b1;
    logic       tick16 = 1'b0;
    logic [5:0] line_ctl = 6'b000011;
    logic       rd_strobe = 1'b0;
    logic [7:0] rx_byte;
    logic       data_ready, parity_err, framing_err, break_det, overrun;

    int vectors = 0;
    int miss = 0;
    bit ended = 0;
    int tdiv = 0;

    serfmt_rx i_serfmt_rx (
        .clk(clk), .rst(rst), .rx_in(rx_in), .tick16(tick16),
        .line_ctl(line_ctl), .rd_strobe(rd_strobe), .rx_byte(rx_byte),
        .data_ready(data_ready), .parity_err(parity_err),
        .framing_err(framing_err), .break_det(break_det), .overrun(overrun)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        tdiv   <= (tdiv == 3) ? 0 : tdiv + 1;
        tick16 <= (tdiv == 3);
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miss++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic ticks(input int k);
        repeat (k) begin
            @(posedge clk);
            while (!tick16) @(posedge clk);
        end
        @(negedge clk);
    endtask

    function automatic logic par_bit(input logic [7:0] d, input bit even, input bit stick);
        if (stick) return !even;
        return even ? ($countones(d) % 2 == 1) : ($countones(d) % 2 == 0);
    endfunction

    task automatic send_char(input logic [7:0] d, input int n, input bit has_par,
                             input bit pbit, input bit stopv, input int idle);
        rx_in = 1'b0;
        ticks(16);
        for (int i = 0; i < n; i++) begin
            rx_in = d[i];
            ticks(16);
        end
        if (has_par) begin
            rx_in = pbit;
            ticks(16);
        end
        rx_in = stopv;
        ticks(16);
        rx_in = 1'b1;
        if (idle > 0) ticks(idle);
    endtask

    task automatic do_read();
        @(negedge clk) rd_strobe = 1'b1;
        @(negedge clk) rd_strobe = 1'b0;
    endtask

    task automatic t_reset();
        chk("R10", "data_ready", data_ready, 0);
        chk("R10", "overrun", overrun, 0);
        chk("R10", "flags", {parity_err, framing_err, break_det}, 0);
        chk("R10", "rx_byte", rx_byte, 0);
    endtask

    task automatic t_lengths();
        for (int n = 5; n <= 8; n++) begin
            logic [7:0] mask;
            mask = 8'((16'h1 << n) - 1);
            line_ctl = {4'b0000, 2'(n - 5)};
            send_char(8'hB7, n, 0, 0, 1, 2);
            chk("R1", "len byte", rx_byte, 8'hB7 & mask);
            chk("R8", "ready set", data_ready, 1);
            do_read();
            chk("R8", "ready cleared", data_ready, 0);
        end
        line_ctl = 6'b000011;
        send_char(8'h01, 8, 0, 0, 1, 2);
        chk("R1", "lsb first", rx_byte, 8'h01);
        do_read();
    endtask

    task automatic t_parity();
        logic [7:0] d;
        d = 8'h6A;
        line_ctl = 6'b011011;  // even, 8 bits
        send_char(d, 8, 1, par_bit(d, 1, 0), 1, 2);
        chk("R2", "even good", parity_err, 0);
        do_read();
        send_char(d, 8, 1, !par_bit(d, 1, 0), 1, 2);
        chk("R2", "even bad", parity_err, 1);
        do_read();
        line_ctl = 6'b001010;  // odd, 7 bits
        send_char(8'h13, 7, 1, par_bit(8'h13, 0, 0), 1, 2);
        chk("R2", "odd good", parity_err, 0);
        chk("R2", "odd byte", rx_byte, 8'h13);
        do_read();
        send_char(8'h13, 7, 1, !par_bit(8'h13, 0, 0), 1, 2);
        chk("R2", "odd bad", parity_err, 1);
        do_read();
    endtask

    task automatic t_stick();
        line_ctl = 6'b111011;  // stick, even set: expect 0
        send_char(8'h01, 8, 1, 0, 1, 2);
        chk("R3", "stick even ok", parity_err, 0);
        do_read();
        send_char(8'h01, 8, 1, 1, 1, 2);
        chk("R3", "stick even bad", parity_err, 1);
        do_read();
        line_ctl = 6'b101011;  // stick, even clear: expect 1
        send_char(8'h03, 8, 1, 1, 1, 2);
        chk("R3", "stick odd ok", parity_err, 0);
        do_read();
        send_char(8'h03, 8, 1, 0, 1, 2);
        chk("R3", "stick odd bad", parity_err, 1);
        do_read();
    endtask

    task automatic t_two_stop();
        line_ctl = 6'b000111;
        send_char(8'hC3, 8, 0, 0, 1, 0);
        chk("R4", "first byte", rx_byte, 8'hC3);
        do_read();
        send_char(8'h5A, 8, 0, 0, 1, 2);
        chk("R4", "back-to-back ready", data_ready, 1);
        chk("R4", "back-to-back byte", rx_byte, 8'h5A);
        chk("R4", "no ferr", framing_err, 0);
        do_read();
    endtask

    task automatic t_framing();
        line_ctl = 6'b000011;
        send_char(8'h81, 8, 0, 0, 0, 2);
        chk("R5", "ferr", framing_err, 1);
        chk("R5", "no brk", break_det, 0);
        do_read();
        send_char(8'h81, 8, 0, 0, 1, 2);
        chk("R5", "ferr cleared on good char", framing_err, 0);
        do_read();
    endtask

    task automatic t_break();
        line_ctl = 6'b011011;
        send_char(8'h00, 8, 1, 0, 0, 2);
        chk("R6", "brk", break_det, 1);
        chk("R6", "ferr", framing_err, 1);
        chk("R6", "byte", rx_byte, 0);
        do_read();
        send_char(8'h00, 8, 1, 1, 0, 2);
        chk("R6", "parity high no brk", break_det, 0);
        do_read();
    endtask

    task automatic t_glitch();
        line_ctl = 6'b000011;
        rx_in = 1'b0;
        ticks(4);
        rx_in = 1'b1;
        ticks(200);
        chk("R7", "no char", data_ready, 0);
        send_char(8'h3C, 8, 0, 0, 1, 2);
        chk("R7", "recovers", rx_byte, 8'h3C);
        do_read();
    endtask

    task automatic t_overrun();
        line_ctl = 6'b000011;
        send_char(8'h11, 8, 0, 0, 1, 2);
        chk("R9", "no ovr first", overrun, 0);
        send_char(8'h22, 8, 0, 0, 1, 2);
        chk("R9", "ovr set", overrun, 1);
        chk("R9", "newest byte", rx_byte, 8'h22);
        do_read();
        chk("R9", "ovr cleared", overrun, 0);
        chk("R8", "ready cleared", data_ready, 0);
    endtask

    task automatic t_nopar();
        line_ctl = 6'b010011;  // even select but parity off
        send_char(8'hFE, 8, 0, 0, 1, 2);
        chk("R11", "perr", parity_err, 0);
        chk("R11", "byte", rx_byte, 8'hFE);
        chk("R11", "ferr", framing_err, 0);
        do_read();
    endtask

    initial begin
        #1500000;
        if (!ended) begin
            ended = 1;
            miss++;
            $display("FAIL watchdog: actual running expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        ticks(4);
        t_lengths();
        t_parity();
        t_stick();
        t_two_stop();
        t_framing();
        t_break();
        t_glitch();
        t_overrun();
        t_nopar();
        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
            $finish;
        end
    end
endmodule